// File: doc/BRIEF.md
# Register-List Stack Frame Sequencer

This block builds and tears down a stack frame over a fixed band of twelve general registers, r20 to r31. A caller supplies a per-register selection mask, a frame size in words, the current stack pointer and, for teardown, an optional jump-target register number. After a one-cycle start pulse the block runs a sequence of word transfers over a single memory port. It reads register values through a register-file read port and writes popped values back through a register-file write port. At the end it returns the new stack pointer and, when asked for, a jump target.

In build mode the selected registers are pushed from r20 upward. Each push first moves the stack pointer down by one word and then stores the register there, so lower-numbered registers end up at higher addresses. After the last push the local area, frame size times four bytes, is reserved below the saved registers. In teardown mode the local area is released first. The selected registers are then popped from r31 downward, each from the current stack pointer, which then moves up one word. If a nonzero target register number was given, that register's value after the pops is offered as the jump target.

Top module: `stack_frame_seq`

## Requirements
- R1: Only registers whose mask bit is set are transferred (mask bit i stands for register r(20+i)). The number of memory transfers equals the number of set mask bits, and registers that are not selected are never written.
- R2: In build mode (mode_in = 0) the registers are stored in ascending order. The k-th store (k counted from 1) writes the register value to address sp_in - 4k.
- R3: In build mode the final stack pointer is sp_in - 4*(selected count) - 4*frame_words.
- R4: In teardown mode (mode_in = 1) the stack pointer is first raised by 4*frame_words, and the first load reads from sp_in + 4*frame_words.
- R5: In teardown mode the registers are loaded in descending order, r31 first. Each load reads the word at the current stack pointer into the register and then raises the stack pointer by 4. The final stack pointer is sp_in + 4*frame_words + 4*(selected count).
- R6: In teardown mode with target_reg nonzero, done comes with jump_valid = 1 and jump_target equal to that register's value after all pops. With target_reg = 0, or in build mode, jump_valid is 0 at done.
- R7: While mem_req is high and mem_ready is low, the sequencer holds: mem_req stays high and mem_addr does not change.
- R8: done is high for exactly one cycle per operation, and it is low after reset.
- R9: An operation with an empty mask and a zero frame size raises done in the cycle after start and returns sp_in unchanged. In teardown mode this also requires target_reg = 0.
- R10: A start pulse that arrives while an operation is in progress is ignored and does not change that operation's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode_in | input | 1 | 0 = build (push), 1 = teardown (pop) |
| reg_mask | input | NREG | Selection mask, bit i = register REG_BASE+i |
| frame_words | input | FRAME_W | Local area size in words |
| target_reg | input | RIDX_W | Teardown jump register, 0 = no jump |
| sp_in | input | XLEN | Stack pointer at start |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | XLEN | Final stack pointer, valid at done |
| jump_valid | output | 1 | Jump target valid, qualified by done |
| jump_target | output | XLEN | Jump target, qualified by done |
| rf_raddr | output | RIDX_W | Register-file read address |
| rf_rdata | input | XLEN | Register-file read data (same cycle) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | RIDX_W | Register-file write address |
| rf_wdata | output | XLEN | Register-file write data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | XLEN | Byte address of the word |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Load data (same cycle as mem_ready) |
| mem_ready | input | 1 | Transfer completes on this cycle |

## Verification
The bench builds the block with its default parameters: twelve list registers starting at r20, a 5-bit frame size and 32-bit words. With these values all 4096 masks fit in one sweep for each mode, so every push and pop ordering is exercised, together with the empty list, the full list and every frame size from 0 to 31. Jump targets cover every register number, both inside and outside the popped band. Pseudo-random memory stalls and a mid-operation start pulse on a share of the runs cover the hold behaviour and the rule that a start during an operation is ignored.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int SFS_XLEN       = 32;
    localparam int SFS_NREG       = 12;
    localparam int SFS_REG_BASE   = 20;
    localparam int SFS_RIDX_W     = 5;
    localparam int SFS_FRAME_W    = 5;
    localparam int SFS_WORD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TGT  = 2'd2,
        ST_FIN  = 2'd3
    } sfs_state_e;

    typedef enum logic {
        MODE_BUILD = 1'b0,
        MODE_TEAR  = 1'b1
    } sfs_mode_e;

    // True when at most one bit of the list remains.
    function automatic logic last_entry(input logic [SFS_NREG-1:0] v);
        return (v & (v - 1'b1)) == '0;
    endfunction

endpackage

// File: rtl/sfs_pick.sv
module sfs_pick #(
    parameter int N         = 12,
    parameter bit LOW_FIRST = 1'b1,
    localparam int IW       = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    assign any = |vec;

    generate
        if (LOW_FIRST) begin : g_low
            // Scan downward so the lowest set bit is written last.
            always_comb begin
                idx = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (vec[i]) idx = IW'(i);
                end
            end
        end else begin : g_high
            // Scan upward so the highest set bit is written last.
            always_comb begin
                idx = '0;
                for (int i = 0; i < N; i++) begin
                    if (vec[i]) idx = IW'(i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sfs_math.sv
module sfs_math #(
    parameter int XLEN       = 32,
    parameter int FRAME_W    = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [XLEN-1:0]    base,
    input  logic [FRAME_W-1:0] frame,
    output logic [XLEN-1:0]    step_dn,
    output logic [XLEN-1:0]    step_up,
    output logic [XLEN-1:0]    frm_dn,
    output logic [XLEN-1:0]    frm_up,
    output logic [XLEN-1:0]    step_frm_dn
);

    localparam int            SH    = $clog2(WORD_BYTES);
    localparam logic [XLEN-1:0] WSTEP = XLEN'(WORD_BYTES);

    logic [XLEN-1:0] fbytes;

    assign fbytes      = XLEN'(frame) << SH;
    assign step_dn     = base - WSTEP;
    assign step_up     = base + WSTEP;
    assign frm_dn      = base - fbytes;
    assign frm_up      = base + fbytes;
    // Last push and the local-area reservation merged into one update.
    assign step_frm_dn = base - WSTEP - fbytes;

endmodule

// File: rtl/sfs_fsm.sv
module sfs_fsm
    import sfs_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NREG    = 12,
    parameter int RIDX_W  = 5,
    parameter int FRAME_W = 5,
    localparam int IW     = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               mode_in,
    input  logic [NREG-1:0]    mask_in,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [RIDX_W-1:0]  tgt_in,
    input  logic [XLEN-1:0]    sp_in,
    input  logic               mem_ready,
    input  logic [XLEN-1:0]    rf_rdata,
    input  logic [IW-1:0]      pick_idx,
    input  logic [XLEN-1:0]    step_dn,
    input  logic [XLEN-1:0]    step_up,
    input  logic [XLEN-1:0]    frm_dn,
    input  logic [XLEN-1:0]    frm_up,
    input  logic [XLEN-1:0]    step_frm_dn,
    output sfs_state_e         state_o,
    output sfs_mode_e          mode_o,
    output logic [NREG-1:0]    rem_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic [RIDX_W-1:0]  tgt_o,
    output logic [XLEN-1:0]    sp_o,
    output logic               jvalid_o,
    output logic [XLEN-1:0]    jtgt_o
);

    sfs_state_e         state;
    sfs_mode_e          mode_q;
    logic [NREG-1:0]    rem;
    logic [FRAME_W-1:0] frame_q;
    logic [RIDX_W-1:0]  tgt_q;
    logic [XLEN-1:0]    sp_q;
    logic               jv_q;
    logic [XLEN-1:0]    jt_q;

    logic            last;
    logic [NREG-1:0] rem_next;

    assign last     = ((rem & (rem - 1'b1)) == '0);
    assign rem_next = rem & ~(NREG'(1) << pick_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            mode_q  <= MODE_BUILD;
            rem     <= '0;
            frame_q <= '0;
            tgt_q   <= '0;
            sp_q    <= '0;
            jv_q    <= 1'b0;
            jt_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= sfs_mode_e'(mode_in);
                        rem     <= mask_in;
                        frame_q <= frame_in;
                        tgt_q   <= tgt_in;
                        jv_q    <= 1'b0;
                        if (mode_in == MODE_TEAR) begin
                            // Release the local area before any pop.
                            sp_q <= frm_up;
                            if (mask_in != '0)     state <= ST_XFER;
                            else if (tgt_in != '0) state <= ST_TGT;
                            else                   state <= ST_FIN;
                        end else if (mask_in != '0) begin
                            sp_q  <= sp_in;
                            state <= ST_XFER;
                        end else begin
                            sp_q  <= frm_dn;
                            state <= ST_FIN;
                        end
                    end
                end
                ST_XFER: begin
                    if (mem_ready) begin
                        rem <= rem_next;
                        if (mode_q == MODE_BUILD) begin
                            sp_q <= last ? step_frm_dn : step_dn;
                            if (last) state <= ST_FIN;
                        end else begin
                            sp_q <= step_up;
                            if (last) state <= (tgt_q != '0) ? ST_TGT : ST_FIN;
                        end
                    end
                end
                ST_TGT: begin
                    jt_q  <= rf_rdata;
                    jv_q  <= 1'b1;
                    state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign state_o  = state;
    assign mode_o   = mode_q;
    assign rem_o    = rem;
    assign frame_o  = frame_q;
    assign tgt_o    = tgt_q;
    assign sp_o     = sp_q;
    assign jvalid_o = jv_q;
    assign jtgt_o   = jt_q;

    // Each completed transfer retires exactly one list entry.
    p_one_per_xfer_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER && mem_ready) |=> ($countones(rem) == $countones($past(rem)) - 1));

    // A stalled transfer leaves the list and the stack pointer alone.
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER && !mem_ready) |=> (state == ST_XFER && $stable(rem) && $stable(sp_q)));

    // The completion state lasts one cycle.
    p_fin_once_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN) |=> (state == ST_IDLE));

    // An empty build with no local area finishes at once and keeps SP.
    p_empty_fast_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && mask_in == '0 && frame_in == '0 && mode_in == MODE_BUILD)
        |=> (state == ST_FIN && sp_q == $past(sp_in)));

    // A start pulse during an operation leaves the latched mode alone.
    p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> (mode_q == $past(mode_q) && tgt_q == $past(tgt_q)));

endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
    import sfs_pkg::*;
#(
    parameter int XLEN       = SFS_XLEN,
    parameter int NREG       = SFS_NREG,
    parameter int REG_BASE   = SFS_REG_BASE,
    parameter int RIDX_W     = SFS_RIDX_W,
    parameter int FRAME_W    = SFS_FRAME_W,
    parameter int WORD_BYTES = SFS_WORD_BYTES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               mode_in,
    input  logic [NREG-1:0]    reg_mask,
    input  logic [FRAME_W-1:0] frame_words,
    input  logic [RIDX_W-1:0]  target_reg,
    input  logic [XLEN-1:0]    sp_in,
    output logic               done,
    output logic [XLEN-1:0]    sp_out,
    output logic               jump_valid,
    output logic [XLEN-1:0]    jump_target,
    output logic [RIDX_W-1:0]  rf_raddr,
    input  logic [XLEN-1:0]    rf_rdata,
    output logic               rf_we,
    output logic [RIDX_W-1:0]  rf_waddr,
    output logic [XLEN-1:0]    rf_wdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic [XLEN-1:0]    mem_rdata,
    input  logic               mem_ready
);

    localparam int IW = $clog2(NREG);

    sfs_state_e         state;
    sfs_mode_e          mode_q;
    logic [NREG-1:0]    rem;
    logic [FRAME_W-1:0] frame_q;
    logic [RIDX_W-1:0]  tgt_q;
    logic [XLEN-1:0]    sp_q;

    logic [IW-1:0]      idx_lo, idx_hi, pick_idx;
    logic               any_lo, any_hi;
    logic [RIDX_W-1:0]  cur_reg;

    logic [XLEN-1:0]    m_base;
    logic [FRAME_W-1:0] m_frame;
    logic [XLEN-1:0]    step_dn, step_up, frm_dn, frm_up, step_frm_dn;

    // Build walks upward from the lowest register, teardown downward.
    sfs_pick #(.N(NREG), .LOW_FIRST(1'b1)) u_pick_lo (
        .vec (rem),
        .any (any_lo),
        .idx (idx_lo)
    );

    sfs_pick #(.N(NREG), .LOW_FIRST(1'b0)) u_pick_hi (
        .vec (rem),
        .any (any_hi),
        .idx (idx_hi)
    );

    assign pick_idx = (mode_q == MODE_BUILD) ? idx_lo : idx_hi;
    assign cur_reg  = RIDX_W'(REG_BASE) + RIDX_W'(pick_idx);

    // One adder set serves the start cycle (sp_in) and the transfers (sp_q).
    assign m_base  = (state == ST_IDLE) ? sp_in : sp_q;
    assign m_frame = (state == ST_IDLE) ? frame_words : frame_q;

    sfs_math #(.XLEN(XLEN), .FRAME_W(FRAME_W), .WORD_BYTES(WORD_BYTES)) u_math (
        .base        (m_base),
        .frame       (m_frame),
        .step_dn     (step_dn),
        .step_up     (step_up),
        .frm_dn      (frm_dn),
        .frm_up      (frm_up),
        .step_frm_dn (step_frm_dn)
    );

    sfs_fsm #(.XLEN(XLEN), .NREG(NREG), .RIDX_W(RIDX_W), .FRAME_W(FRAME_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .mode_in     (mode_in),
        .mask_in     (reg_mask),
        .frame_in    (frame_words),
        .tgt_in      (target_reg),
        .sp_in       (sp_in),
        .mem_ready   (mem_ready),
        .rf_rdata    (rf_rdata),
        .pick_idx    (pick_idx),
        .step_dn     (step_dn),
        .step_up     (step_up),
        .frm_dn      (frm_dn),
        .frm_up      (frm_up),
        .step_frm_dn (step_frm_dn),
        .state_o     (state),
        .mode_o      (mode_q),
        .rem_o       (rem),
        .frame_o     (frame_q),
        .tgt_o       (tgt_q),
        .sp_o        (sp_q),
        .jvalid_o    (jump_valid),
        .jtgt_o      (jump_target)
    );

    assign mem_req   = (state == ST_XFER);
    assign mem_we    = mem_req && (mode_q == MODE_BUILD);
    assign mem_addr  = (mode_q == MODE_BUILD) ? step_dn : sp_q;
    assign mem_wdata = rf_rdata;

    assign rf_raddr  = (state == ST_TGT) ? tgt_q : cur_reg;
    assign rf_we     = mem_req && mem_ready && (mode_q == MODE_TEAR);
    assign rf_waddr  = cur_reg;
    assign rf_wdata  = mem_rdata;

    assign done   = (state == ST_FIN);
    assign sp_out = sp_q;

    // Stalled request keeps its address until the memory answers.
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // No jump unless a target register was named.
    p_no_jump_r6: assert property (@(posedge clk) disable iff (rst)
        (done && tgt_q == '0) |-> !jump_valid);

    // A transfer request always has a list entry behind it.
    p_req_has_entry_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (any_lo && any_hi));

    // The done pulse never repeats back to back.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/stack_frame_seq_test.sv
`timescale 1ns/1ps
module stack_frame_seq_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        mode_in;
    logic [11:0] reg_mask;
    logic [4:0]  frame_words;
    logic [4:0]  target_reg;
    logic [31:0] sp_in;
    logic        done;
    logic [31:0] sp_out;
    logic        jump_valid;
    logic [31:0] jump_target;
    logic [4:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ready;

    logic [31:0] rf  [0:31];
    logic [31:0] mem [0:1023];

    int checks = 0;
    int fails  = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = mem[mem_addr[11:2]];

    stack_frame_seq uut (
        .clk(clk), .rst(rst), .start(start), .mode_in(mode_in),
        .reg_mask(reg_mask), .frame_words(frame_words), .target_reg(target_reg),
        .sp_in(sp_in), .done(done), .sp_out(sp_out), .jump_valid(jump_valid),
        .jump_target(jump_target), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [31:0] reg_val(input int r, input int tag);
        return {tag[15:0], 8'h5A, 8'(r)};
    endfunction

    function automatic logic [31:0] stk_val(input int i, input int tag);
        return {tag[15:0], 8'hC3, 8'(i)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input bit tear, input logic [11:0] mask, input logic [4:0] frm,
                            input logic [4:0] tsel, input bit poke, input int tag);
        int pop, cyc, nxfer, k;
        logic [31:0] sp0, first_addr, prev_addr, exp_sp, got_sp, got_jt;
        bit prev_stall, stall_bad, got_done, first_seen, got_jv, wrong_dir;
        sp0 = 32'h0000_0800;
        pop = $countones(mask);
        for (int r = 0; r < 32; r++)
            rf[r] = (tear && r >= 20) ? (32'hBAD0_0000 | 32'(r)) : reg_val(r, tag);
        for (int w = 440; w < 620; w++) mem[w] = 32'hEEEE_0000 | 32'(w);
        if (tear) begin
            k = 0;
            for (int i = 11; i >= 0; i--) begin
                if (mask[i]) begin
                    mem[(sp0 + 32'(4 * frm) + 32'(4 * k)) >> 2] = stk_val(i, tag);
                    k++;
                end
            end
        end
        @(negedge clk);
        start = 1'b1; mode_in = tear; reg_mask = mask; frame_words = frm;
        target_reg = tsel; sp_in = sp0;
        cyc = 0; nxfer = 0; got_done = 0; first_seen = 0; prev_stall = 0;
        stall_bad = 0; wrong_dir = 0; first_addr = '0; prev_addr = '0;
        got_sp = '0; got_jv = 0; got_jt = '0;
        while (!got_done && cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 2) begin
                start = 1'b1; mode_in = !tear; sp_in = 32'hDEAD_0000;
                reg_mask = ~mask; target_reg = ~tsel;
            end else begin
                start = 1'b0;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready = |lfsr[1:0];
            #1;
            if (prev_stall && (!mem_req || mem_addr != prev_addr)) stall_bad = 1;
            prev_stall = mem_req && !mem_ready;
            prev_addr  = mem_addr;
            if (mem_req && mem_ready) begin
                if (!first_seen) begin first_addr = mem_addr; first_seen = 1; end
                nxfer++;
                if (mem_we != !tear) wrong_dir = 1;
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                if (rf_we)  rf[rf_waddr] = rf_wdata;
            end
            if (done) begin
                got_done = 1; got_sp = sp_out; got_jv = jump_valid; got_jt = jump_target;
            end
        end
        mem_ready = 1'b0;
        chk(got_done, "R8 (done seen)", 32'(got_done), 32'd1);
        chk(nxfer == pop, "R1 (transfer count)", 32'(nxfer), 32'(pop));
        chk(!wrong_dir, "R1 (transfer direction)", 32'(wrong_dir), 32'd0);
        chk(!stall_bad, "R7 (hold under stall)", 32'(stall_bad), 32'd0);
        if (!tear) begin
            exp_sp = sp0 - 32'(4 * pop) - 32'(4 * frm);
            chk(got_sp == exp_sp, "R3 (build final SP)", got_sp, exp_sp);
            if (pop > 0) chk(first_addr == sp0 - 32'd4, "R2 (first store addr)", first_addr, sp0 - 32'd4);
            k = 0;
            for (int i = 0; i < 12; i++) begin
                if (mask[i]) begin
                    k++;
                    chk(mem[(sp0 - 32'(4 * k)) >> 2] == reg_val(20 + i, tag), "R2 (stored word)",
                        mem[(sp0 - 32'(4 * k)) >> 2], reg_val(20 + i, tag));
                end
            end
            chk(!got_jv, "R6 (no jump in build)", 32'(got_jv), 32'd0);
        end else begin
            exp_sp = sp0 + 32'(4 * frm) + 32'(4 * pop);
            chk(got_sp == exp_sp, "R5 (teardown final SP)", got_sp, exp_sp);
            if (pop > 0) chk(first_addr == sp0 + 32'(4 * frm), "R4 (first load addr)",
                             first_addr, sp0 + 32'(4 * frm));
            for (int i = 11; i >= 0; i--) begin
                if (mask[i])
                    chk(rf[20 + i] == stk_val(i, tag), "R5 (popped value)", rf[20 + i], stk_val(i, tag));
                else
                    chk(rf[20 + i] == (32'hBAD0_0000 | 32'(20 + i)), "R1 (unselected untouched)",
                        rf[20 + i], 32'hBAD0_0000 | 32'(20 + i));
            end
            if (tsel != 5'd0) begin
                chk(got_jv, "R6 (jump valid)", 32'(got_jv), 32'd1);
                chk(got_jt == rf[tsel], "R6 (jump target)", got_jt, rf[tsel]);
            end else begin
                chk(!got_jv, "R6 (no jump)", 32'(got_jv), 32'd0);
            end
        end
        if (mask == '0 && frm == '0 && (!tear || tsel == 5'd0)) begin
            chk(cyc == 1, "R9 (one-cycle empty)", 32'(cyc), 32'd1);
            chk(got_sp == sp0, "R9 (SP unchanged)", got_sp, sp0);
        end
        if (poke) chk(got_sp == exp_sp, "R10 (busy start ignored)", got_sp, exp_sp);
        @(negedge clk);
        #1;
        chk(!done, "R8 (single-cycle done)", 32'(done), 32'd0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mode_in = 1'b0; reg_mask = '0; frame_words = '0;
        target_reg = '0; sp_in = '0; mem_ready = 1'b0;
        for (int r = 0; r < 32; r++) rf[r] = '0;
        for (int w = 0; w < 1024; w++) mem[w] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(!done, "R8 (reset done low)", 32'(done), 32'd0);
        chk(!mem_req && !rf_we, "R8 (reset idle ports)", 32'({mem_req, rf_we}), 32'd0);
        rst = 1'b0;
        for (int m = 0; m < 4096; m++) begin
            run_case(1'b0, 12'(m), 5'((m * 7) % 32), 5'd0,
                     (m % 5 == 0) && ($countones(12'(m)) >= 2), m);
            run_case(1'b1, 12'(m), 5'((m * 3) % 32), 5'(m % 32),
                     (m % 5 == 1) && ($countones(12'(m)) >= 2), m + 4096);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 195000);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule